// File: doc/BRIEF.md
# Byte-Lane Write Steering with Narrow-Bus Splitting

This block sits on the write path between a 32-bit bus master and a system bus whose width can be 32 or 16 bits from one cycle to the next. The master hands it a 32-bit logical write word and four active-low byte enables. The block drives the full physical data word on every write. When only upper-half bytes are enabled, it copies them onto the lower half, so that a 16-bit device on bits 15:0 can take them without extra cycles.

Each bus sub-cycle has two phases. The first is an address phase: `bus_start` is high and the acknowledge input is ignored. The second is a wait phase, in which the acknowledge is sampled on every clock until it is seen low. An active-low narrow-size input is sampled together with the acknowledge. If the operand covers both halves and the bus reports 16-bit width, the block runs a second sub-cycle by itself. That sub-cycle carries only the upper enables, and the upper bytes are steered down to bits 15:0. A one-cycle `done` pulse marks the end of the whole write.

Top module: `wsteer_top`

## Requirements
- R1: Enable bit i (active low) selects lane i, where lane 0 is data bits 7:0, lane 1 is 15:8, lane 2 is 23:16 and lane 3 is 31:24. For every enable pattern other than those in R2 to R4, each enabled lane carries its own byte of the write word and every disabled lane is driven to zero.
- R2: With only lane 2 enabled (`bus_be_n`=4'b1011), byte 23:16 of the word appears on both bits 23:16 and bits 7:0. All other bits are zero.
- R3: With only lane 3 enabled (`bus_be_n`=4'b0111), byte 31:24 appears on both bits 31:24 and bits 15:8. All other bits are zero.
- R4: With only lanes 2 and 3 enabled (`bus_be_n`=4'b0011), bits 31:16 of the word appear on both bits 31:16 and bits 15:0.
- R5: After reset, and whenever no write is in progress, `busy` and `done` are low, `bus_be_n` is 4'b1111 and `bus_data` is zero.
- R6: A write is accepted when `start` is high while `busy` is low. `bus_start` is high in the following cycle. A `start` that arrives while `busy` is high is ignored.
- R7: `ack_n` is ignored in the address phase (`bus_start` high). In the wait phase it is sampled every cycle, and the bus outputs stay unchanged until it is seen low.
- R8: `size16_n` low has no extra effect when the enabled lanes all lie in one half: the write ends after a single sub-cycle.
- R9: If `size16_n` is low when the first sub-cycle is acknowledged, and at least one lower lane and at least one upper lane are enabled, a second sub-cycle follows at once. It has `bus_start` high, `bus_be_n` equal to the original enables with bits 1:0 forced to 1, and data steered per R2 to R4.
- R10: `done` is high for exactly one cycle: the cycle after the final sub-cycle is acknowledged. It is not raised after the first half of a split.
- R11: `size16_n` is ignored while the second sub-cycle is acknowledged, so a write never has more than two sub-cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Write request strobe |
| wr_be_n | input | 4 | Logical byte enables, active low |
| wr_data | input | 32 | Logical write word |
| ack_n | input | 1 | Sub-cycle acknowledge, active low |
| size16_n | input | 1 | Current cycle is 16 bits wide, active low |
| busy | output | 1 | A write is in progress |
| bus_start | output | 1 | Address phase of a sub-cycle |
| bus_be_n | output | 4 | Physical byte enables, active low |
| bus_data | output | 32 | Physical write data |
| done | output | 1 | Write fully completed (one-cycle pulse) |

## Verification
A wrong sub-cycle state shows at the ports within one clock: `bus_start` held for two cycles, a missing second address phase after a narrow acknowledge, or a `done` pulse after the first half of a split. Corrupted steering, or a wrong latched enable, shows at once on `bus_data` and `bus_be_n` in the address phase. A zero lane that should hold data, or a missing duplicate, can be compared directly, because undefined lanes are driven to zero. A lost latch shows as bus values that change while the acknowledge is withheld.

// File: rtl/wsteer_pkg.sv
package wsteer_pkg;

    localparam int LANES    = 4;
    localparam int LANE_W   = 8;
    localparam int DATA_W   = LANES * LANE_W;
    localparam int HALF     = LANES / 2;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ADDR = 2'd1,
        ST_WAIT = 2'd2
    } bus_state_e;

    typedef struct packed {
        logic [LANES-1:0]  be_n;
        logic [DATA_W-1:0] data;
    } lane_word_t;

    // Expand an active-low enable nibble into a per-bit keep mask.
    function automatic logic [DATA_W-1:0] lane_mask(input logic [LANES-1:0] be_n);
        logic [DATA_W-1:0] m;
        for (int i = 0; i < LANES; i++) begin
            m[i*LANE_W +: LANE_W] = {LANE_W{~be_n[i]}};
        end
        return m;
    endfunction

    // True when enabled lanes exist in both the lower and the upper half.
    function automatic logic spans_halves(input logic [LANES-1:0] be_n);
        return (~&be_n[HALF-1:0]) && (~&be_n[LANES-1:HALF]);
    endfunction

    // Upper-half-only patterns also drive their bytes onto the lower half.
    function automatic logic upper_only(input logic [LANES-1:0] be_n);
        return (&be_n[HALF-1:0]) && (~&be_n[LANES-1:HALF]);
    endfunction

endpackage

// File: rtl/wsteer_lanes.sv
module wsteer_lanes
    import wsteer_pkg::*;
(
    input  lane_word_t src,
    output lane_word_t dst
);
    localparam int HALF_W = DATA_W / 2;

    logic [DATA_W-1:0] kept;

    always_comb begin
        kept = src.data & lane_mask(src.be_n);
        dst.be_n = src.be_n;
        if (upper_only(src.be_n)) begin
            // Lower half mirrors the (masked) upper half.
            dst.data = {kept[DATA_W-1:HALF_W], kept[DATA_W-1:HALF_W]};
        end else begin
            dst.data = kept;
        end
    end

endmodule

// File: rtl/wsteer_seq.sv
module wsteer_seq
    import wsteer_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [LANES-1:0]  wr_be_n,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              ack_n,
    input  logic              size16_n,
    output logic              busy,
    output logic              addr_phase,
    output logic              done,
    output lane_word_t        cur
);
    localparam logic [LANES-1:0] LOW_OFF = {{(LANES-HALF){1'b0}}, {HALF{1'b1}}};

    bus_state_e        state_q;
    logic              second_q;
    logic              done_q;
    logic [LANES-1:0]  be_q;
    logic [DATA_W-1:0] data_q;
    logic              finish;
    logic              split;

    assign split  = !second_q && !size16_n && spans_halves(be_q);
    assign finish = (state_q == ST_WAIT) && !ack_n && !split;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            second_q <= 1'b0;
            done_q   <= 1'b0;
            be_q     <= '1;
            data_q   <= '0;
        end else begin
            done_q <= finish;
            unique case (state_q)
                ST_IDLE: begin
                    second_q <= 1'b0;
                    if (start) begin
                        be_q    <= wr_be_n;
                        data_q  <= wr_data;
                        state_q <= ST_ADDR;
                    end
                end
                ST_ADDR: state_q <= ST_WAIT;
                ST_WAIT: begin
                    if (!ack_n) begin
                        if (split) begin
                            second_q <= 1'b1;
                            state_q  <= ST_ADDR;
                        end else begin
                            state_q  <= ST_IDLE;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        busy       = (state_q != ST_IDLE);
        addr_phase = (state_q == ST_ADDR);
        done       = done_q;
        if (!busy) begin
            cur.be_n = '1;
            cur.data = '0;
        end else begin
            cur.be_n = second_q ? (be_q | LOW_OFF) : be_q;
            cur.data = data_q;
        end
    end

endmodule

// File: rtl/wsteer_top.sv
module wsteer_top
    import wsteer_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [LANES-1:0]  wr_be_n,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              ack_n,
    input  logic              size16_n,
    output logic              busy,
    output logic              bus_start,
    output logic [LANES-1:0]  bus_be_n,
    output logic [DATA_W-1:0] bus_data,
    output logic              done
);
    lane_word_t seq_word;
    lane_word_t phys_word;

    wsteer_seq u_seq (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .wr_be_n    (wr_be_n),
        .wr_data    (wr_data),
        .ack_n      (ack_n),
        .size16_n   (size16_n),
        .busy       (busy),
        .addr_phase (bus_start),
        .done       (done),
        .cur        (seq_word)
    );

    wsteer_lanes u_lanes (
        .src (seq_word),
        .dst (phys_word)
    );

    assign bus_be_n = phys_word.be_n;
    assign bus_data = phys_word.data;

endmodule

// File: rtl/wsteer_checker.sv
module wsteer_checker
    import wsteer_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic              ack_n,
    input logic              size16_n,
    input logic              busy,
    input logic              bus_start,
    input logic [LANES-1:0]  bus_be_n,
    input logic [DATA_W-1:0] bus_data,
    input logic              done
);
    assert_idle_quiet_R5: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (bus_be_n == 4'b1111 && bus_data == '0));

    assert_accept_R6: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> bus_start);

    assert_addr_one_cycle_R7: assert property (@(posedge clk) disable iff (rst)
        bus_start |=> (!bus_start && busy));

    assert_wait_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (busy && !bus_start && ack_n) |=> (busy && !bus_start && $stable(bus_be_n) && $stable(bus_data)));

    assert_dup_lane2_R2: assert property (@(posedge clk) disable iff (rst)
        (busy && bus_be_n == 4'b1011) |-> (bus_data[7:0] == bus_data[23:16]));

    assert_dup_lane3_R3: assert property (@(posedge clk) disable iff (rst)
        (busy && bus_be_n == 4'b0111) |-> (bus_data[15:8] == bus_data[31:24]));

    assert_split_R9: assert property (@(posedge clk) disable iff (rst)
        (busy && !bus_start && !ack_n && !size16_n && bus_be_n[1:0] != 2'b11 && bus_be_n[3:2] != 2'b11)
        |=> (bus_start && bus_be_n[1:0] == 2'b11));

    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_done_idle_R10: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

endmodule

bind wsteer_top wsteer_checker u_wsteer_checker (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .ack_n     (ack_n),
    .size16_n  (size16_n),
    .busy      (busy),
    .bus_start (bus_start),
    .bus_be_n  (bus_be_n),
    .bus_data  (bus_data),
    .done      (done)
);

// File: tb/test_wsteer_top.sv
module test_wsteer_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        start;
    logic [3:0]  wr_be_n;
    logic [31:0] wr_data;
    logic        ack_n;
    logic        size16_n;
    logic        busy;
    logic        bus_start;
    logic [3:0]  bus_be_n;
    logic [31:0] bus_data;
    logic        done;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    wsteer_top i_wsteer_top (
        .clk(clk), .rst(rst), .start(start), .wr_be_n(wr_be_n), .wr_data(wr_data),
        .ack_n(ack_n), .size16_n(size16_n), .busy(busy), .bus_start(bus_start),
        .bus_be_n(bus_be_n), .bus_data(bus_data), .done(done)
    );

    typedef struct packed {
        logic [3:0]  be;
        logic [31:0] wd;
        logic        sz_n;
        logic [31:0] exp1;
        logic        split;
        logic [3:0]  be2;
        logic [31:0] exp2;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VECS [NV] = '{
        '{4'b1110, 32'hDDCCBBAA, 1'b1, 32'h000000AA, 1'b0, 4'hF, 32'h0},
        '{4'b1101, 32'hDDCCBBAA, 1'b1, 32'h0000BB00, 1'b0, 4'hF, 32'h0},
        '{4'b1011, 32'hDDCCBBAA, 1'b1, 32'h00CC00CC, 1'b0, 4'hF, 32'h0},
        '{4'b0111, 32'hDDCCBBAA, 1'b1, 32'hDD00DD00, 1'b0, 4'hF, 32'h0},
        '{4'b1100, 32'hDDCCBBAA, 1'b1, 32'h0000BBAA, 1'b0, 4'hF, 32'h0},
        '{4'b1001, 32'hDDCCBBAA, 1'b1, 32'h00CCBB00, 1'b0, 4'hF, 32'h0},
        '{4'b0011, 32'h44332211, 1'b1, 32'h44334433, 1'b0, 4'hF, 32'h0},
        '{4'b0000, 32'h44332211, 1'b1, 32'h44332211, 1'b0, 4'hF, 32'h0},
        '{4'b1010, 32'hDDCCBBAA, 1'b1, 32'h00CC00AA, 1'b0, 4'hF, 32'h0},
        '{4'b1100, 32'hDDCCBBAA, 1'b0, 32'h0000BBAA, 1'b0, 4'hF, 32'h0},
        '{4'b0011, 32'hDDCCBBAA, 1'b0, 32'hDDCCDDCC, 1'b0, 4'hF, 32'h0},
        '{4'b1001, 32'hDDCCBBAA, 1'b0, 32'h00CCBB00, 1'b1, 4'b1011, 32'h00CC00CC},
        '{4'b0001, 32'hDDCCBBAA, 1'b0, 32'hDDCCBB00, 1'b1, 4'b0011, 32'hDDCCDDCC},
        '{4'b0000, 32'h44332211, 1'b0, 32'h44332211, 1'b1, 4'b0011, 32'h44334433},
        '{4'b1010, 32'hDDCCBBAA, 1'b0, 32'h00CC00AA, 1'b1, 4'b1011, 32'h00CC00CC},
        '{4'b0110, 32'hDDCCBBAA, 1'b0, 32'hDD0000AA, 1'b1, 4'b0111, 32'hDD00DD00}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    // Address phase of one sub-cycle has just been entered.
    task automatic chk_addr(input logic [3:0] be, input logic [31:0] exp);
        chk("R6 bus_start in address phase", {31'b0, bus_start}, 32'd1);
        chk("R1 enables on bus", {28'b0, bus_be_n}, {28'b0, be});
        chk("R1/R2/R3/R4 steered data", bus_data, exp);
    endtask

    task automatic run_vec(input vec_t v);
        @(negedge clk);
        start = 1'b1; wr_be_n = v.be; wr_data = v.wd; ack_n = 1'b1; size16_n = v.sz_n;
        @(negedge clk);
        start = 1'b0;
        chk_addr(v.be, v.exp1);
        ack_n = 1'b0; // low during address phase: must be ignored
        @(negedge clk);
        chk("R7 ack ignored in address phase", {30'b0, busy, bus_start}, 32'd2);
        @(negedge clk);
        if (v.split) begin
            chk("R9 second sub-cycle no done", {31'b0, done}, 32'd0);
            chk_addr(v.be2, v.exp2);
            @(negedge clk);
            chk("R9 second wait phase", {30'b0, busy, bus_start}, 32'd2);
            @(negedge clk);
        end
        chk("R10/R11 done after final ack", {30'b0, done, busy}, 32'd2);
        chk("R5 idle bus", {bus_be_n, bus_data[27:0]}, {4'hF, 28'h0});
        ack_n = 1'b1; size16_n = 1'b1;
        @(negedge clk);
        chk("R10 done one cycle", {31'b0, done}, 32'd0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        rst = 1'b1; start = 1'b0; wr_be_n = 4'hF; wr_data = '0; ack_n = 1'b1; size16_n = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R5: reset state
        chk("R5 reset busy/done", {30'b0, busy, done}, 32'd0);
        chk("R5 reset enables", {28'b0, bus_be_n}, 32'hF);
        chk("R5 reset data", bus_data, 32'h0);

        for (int i = 0; i < NV; i++) run_vec(VECS[i]);

        // R7: wait states hold outputs; R6: start while busy ignored
        @(negedge clk);
        start = 1'b1; wr_be_n = 4'b0011; wr_data = 32'h87654321;
        @(negedge clk);
        start = 1'b1; wr_be_n = 4'b1110; wr_data = 32'h11111111;
        chk_addr(4'b0011, 32'h87658765);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            start = 1'b0;
            chk("R7 wait state holds data", bus_data, 32'h87658765);
            chk("R7 wait state no done", {30'b0, busy, done}, 32'd2);
        end
        ack_n = 1'b0;
        @(negedge clk);
        ack_n = 1'b1;
        chk("R10 done after wait states", {30'b0, done, busy}, 32'd2);
        @(negedge clk);
        chk("R6 start while busy ignored", {30'b0, busy, bus_start}, 32'd0);

        // R8: narrow size, lower lanes only -> single sub-cycle
        run_vec('{4'b1110, 32'h000000F0, 1'b0, 32'h000000F0, 1'b0, 4'hF, 32'h0});

        // R9 with acknowledge delayed in the first half, narrow sampled only at ack
        @(negedge clk);
        start = 1'b1; wr_be_n = 4'b0000; wr_data = 32'hA1B2C3D4; size16_n = 1'b0;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk("R7 narrow without ack no split", {30'b0, busy, bus_start}, 32'd2);
        ack_n = 1'b0;
        @(negedge clk);
        chk_addr(4'b0011, 32'hA1B2A1B2);
        @(negedge clk);
        @(negedge clk);
        ack_n = 1'b1; size16_n = 1'b1;
        chk("R11 no third sub-cycle", {29'b0, done, busy, bus_start}, 32'd4);

        // R5: reset in the middle of a write
        @(negedge clk);
        start = 1'b1; wr_be_n = 4'b0000; wr_data = 32'hFFFFFFFF;
        @(negedge clk);
        start = 1'b0; rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R5 reset aborts write", {busy, done, bus_start, bus_be_n, bus_data[24:0]}, {3'b000, 4'hF, 25'h0});

        @(negedge clk);
        finish_run();
    end

endmodule